// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block takes a parameterized set of interrupt request lines and one reset request, and decides which of them the processor should service next. Each request line is captured on its rising edge into a pending flag. A pending interrupt becomes a candidate only when its own enable bit is set and the global interrupt enable is set. At an instruction boundary the block picks the candidate with the lowest index and produces the program address of its vector, the index it serviced, and a one-cycle acknowledge.

Vectors sit two words apart. Index 0 belongs to reset, and interrupt line i uses index i+1, so priority falls as the vector address rises. A table-select input moves the whole table from address zero to a parameterized boot-region base. Two lock inputs stop interrupts from being accepted while the program counter is in a protected region. When an interrupt is taken, the block clears the global enable and clears only the serviced pending flag. A reset request is taken at once and overrides everything else.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A pending interrupt line i is accepted only while `irq_en[i]` and the global enable `gie` are both 1. While either is 0, no acknowledge is issued for it.
- R2: When several interrupts are eligible in the same cycle, the one with the lowest line index is accepted.
- R3: On acknowledge, `ack_id` is 0 for reset and i+1 for line i, and `vec_addr` = table base + 2 × `ack_id`.
- R4: The table base is 0 when `vec_sel` = 0 and `BOOT_START` when `vec_sel` = 1. The value of `vec_sel` is taken in the accepting cycle.
- R5: While `reset_req` is high, the next clock edge gives `ack`=1 with `ack_id`=0. This does not depend on `boundary`, `gie`, the enables or the locks. The same edge clears `gie` and every pending flag.
- R6: An interrupt (other than reset) is accepted only in a cycle where `boundary` is 1.
- R7: Accepting an interrupt clears `gie` in the same edge that raises `ack`. `ack` lasts one cycle. Only the serviced line's pending flag is cleared, so another pending line is serviced after `gie` is set again.
- R8: A request is latched on its 0-to-1 transition. If it arrives while masked, it stays pending after the line falls and is serviced once it is enabled.
- R9: While `lock_a`=1 and `vec_sel`=0, no interrupt is accepted while `pc` >= `BOOT_START` (the boot region).
- R10: While `lock_b`=1 and `vec_sel`=1, no interrupt is accepted while `pc` < `BOOT_START` (the application region).
- R11: `gie_set` sets `gie` on the next edge, and `gie_clr` clears it. If `gie_set` and `gie_clr` are both high, `gie_set` wins. Acceptance of any request wins over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| reset_req | input | 1 | Reset request, top priority, index 0 |
| irq_req | input | N_IRQ | Interrupt request lines, captured on rising edge |
| irq_en | input | N_IRQ | Per-line enable |
| gie_set | input | 1 | Set global enable |
| gie_clr | input | 1 | Clear global enable |
| boundary | input | 1 | Instruction-boundary strobe |
| vec_sel | input | 1 | 0: table at address 0; 1: table at BOOT_START |
| lock_a | input | 1 | Boot-region protection lock |
| lock_b | input | 1 | Application-region protection lock |
| pc | input | PC_W | Current program counter |
| gie | output | 1 | Global interrupt enable state |
| ack | output | 1 | One-cycle acknowledge |
| ack_id | output | ID_W | Serviced index (0 = reset) |
| vec_addr | output | PC_W | Vector address of the serviced index |

## Verification
The case that is hardest to reach from the ports is an interrupt that stays pending although its request line has already fallen. The stimulus raises a line while it is masked and holds it masked through several boundary strobes to confirm that no acknowledge appears. It then drops the line and enables it, and expects the service to follow. The same approach shows that reset empties the pending flags: a masked line is made pending, reset is requested, and then enabling the line must produce nothing. The lock cases move `pc` across `BOOT_START` while a request waits, and the acknowledge is expected only once `pc` leaves the protected region.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    typedef enum logic [1:0] {
        TAKE_NONE  = 2'd0,
        TAKE_RESET = 2'd1,
        TAKE_IRQ   = 2'd2
    } take_e;

    typedef struct packed {
        take_e      kind;
        logic [7:0] id;
    } decision_t;

    function automatic logic [31:0] vector_of(logic [31:0] base, logic [31:0] id);
        return base + (id << 1);
    endfunction

endpackage

// File: rtl/ivc_pending.sv
module ivc_pending #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic [N-1:0] clr_one,
    input  logic         clr_all,
    output logic [N-1:0] pend
);
    logic [N-1:0] prev_q;
    logic [N-1:0] pend_q;
    logic [N-1:0] rise;

    assign rise = req & ~prev_q;
    assign pend = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= req;
            if (clr_all) pend_q <= '0;
            else         pend_q <= (pend_q & ~clr_one) | rise;
        end
    end
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter #(
    parameter int N    = 16,
    parameter int ID_W = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    elig,
    output logic            any,
    output logic [N-1:0]    grant,
    output logic [ID_W-1:0] idx
);
    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = ID_W'(i);
            end
        end
    end
    assign any = |elig;

    assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && (any == (grant != '0)));

    assert_grant_lowest_R2: assert property (@(posedge clk) disable iff (rst)
        (((grant - 1'b1) & elig & {N{any}}) == '0));
endmodule

// File: rtl/ivc_guard.sv
module ivc_guard #(
    parameter int              PC_W       = 12,
    parameter logic [PC_W-1:0] BOOT_START = 12'hC00
) (
    input  logic [PC_W-1:0] pc,
    input  logic            vec_sel,
    input  logic            lock_a,
    input  logic            lock_b,
    output logic            blocked
);
    logic in_boot;
    assign in_boot = (pc >= BOOT_START);
    assign blocked = (lock_a && !vec_sel && in_boot) ||
                     (lock_b &&  vec_sel && !in_boot);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vec_pkg::*;
#(
    parameter int              N_IRQ      = 16,
    parameter int              PC_W       = 12,
    parameter logic [PC_W-1:0] BOOT_START = 12'hC00,
    localparam int             ID_W       = $clog2(N_IRQ + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reset_req,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             gie_set,
    input  logic             gie_clr,
    input  logic             boundary,
    input  logic             vec_sel,
    input  logic             lock_a,
    input  logic             lock_b,
    input  logic [PC_W-1:0]  pc,
    output logic             gie,
    output logic             ack,
    output logic [ID_W-1:0]  ack_id,
    output logic [PC_W-1:0]  vec_addr
);
    logic [N_IRQ-1:0] pend, elig, grant, clr_one;
    logic [ID_W-1:0]  idx;
    logic             any, blocked, clr_all;
    logic             gie_q, ack_q;
    logic [ID_W-1:0]  id_q;
    logic [PC_W-1:0]  vec_q;
    logic [PC_W-1:0]  base;
    decision_t        dec;

    ivc_pending #(.N(N_IRQ)) u_pending (
        .clk(clk), .rst(rst), .req(irq_req),
        .clr_one(clr_one), .clr_all(clr_all), .pend(pend)
    );

    assign elig = pend & irq_en & {N_IRQ{gie_q}};

    ivc_arbiter #(.N(N_IRQ), .ID_W(ID_W)) u_arbiter (
        .clk(clk), .rst(rst), .elig(elig),
        .any(any), .grant(grant), .idx(idx)
    );

    ivc_guard #(.PC_W(PC_W), .BOOT_START(BOOT_START)) u_guard (
        .pc(pc), .vec_sel(vec_sel), .lock_a(lock_a),
        .lock_b(lock_b), .blocked(blocked)
    );

    always_comb begin
        dec.kind = TAKE_NONE;
        dec.id   = '0;
        if (reset_req) begin
            dec.kind = TAKE_RESET;
        end else if (boundary && !blocked && any) begin
            dec.kind = TAKE_IRQ;
            dec.id   = 8'(idx) + 8'd1;
        end
    end

    assign clr_all = (dec.kind == TAKE_RESET);
    assign clr_one = (dec.kind == TAKE_IRQ) ? grant : '0;
    assign base    = vec_sel ? BOOT_START : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            gie_q <= 1'b0;
            ack_q <= 1'b0;
            id_q  <= '0;
            vec_q <= '0;
        end else begin
            ack_q <= (dec.kind != TAKE_NONE);
            if (dec.kind != TAKE_NONE) begin
                id_q  <= ID_W'(dec.id);
                vec_q <= PC_W'(vector_of(32'(base), 32'(dec.id)));
            end
            if (dec.kind != TAKE_NONE) gie_q <= 1'b0;
            else if (gie_set)          gie_q <= 1'b1;
            else if (gie_clr)          gie_q <= 1'b0;
        end
    end

    assign gie      = gie_q;
    assign ack      = ack_q;
    assign ack_id   = id_q;
    assign vec_addr = vec_q;

    assert_ack_gie_low_R7: assert property (@(posedge clk) disable iff (rst)
        ack |-> !gie);

    assert_irq_at_boundary_R6: assert property (@(posedge clk) disable iff (rst)
        (ack && ack_id != '0) |-> $past(boundary));

    assert_irq_not_blocked_R9: assert property (@(posedge clk) disable iff (rst)
        (ack && ack_id != '0) |-> !$past(blocked));

    assert_reset_taken_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(reset_req) && !$past(rst)) |-> (ack && ack_id == '0));
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
    localparam int          N    = 16;
    localparam int          PW   = 12;
    localparam logic [11:0] BS   = 12'hC00;
    localparam int          IDW  = $clog2(N + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reset_req = 1'b0;
    logic [N-1:0] irq_req = '0, irq_en = '0;
    logic gie_set = 1'b0, gie_clr = 1'b0, boundary = 1'b1;
    logic vec_sel = 1'b0, lock_a = 1'b0, lock_b = 1'b0;
    logic [PW-1:0] pc = '0;
    logic gie, ack;
    logic [IDW-1:0] ack_id;
    logic [PW-1:0] vec_addr;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_vector_ctrl u_irq_vector_ctrl (
        .clk(clk), .rst(rst), .reset_req(reset_req), .irq_req(irq_req),
        .irq_en(irq_en), .gie_set(gie_set), .gie_clr(gie_clr),
        .boundary(boundary), .vec_sel(vec_sel), .lock_a(lock_a),
        .lock_b(lock_b), .pc(pc), .gie(gie), .ack(ack),
        .ack_id(ack_id), .vec_addr(vec_addr)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_gie();
        gie_set = 1'b1; step(); gie_set = 1'b0;
    endtask

    task automatic expect_ack(input string req, input int id, input int vec);
        bit got = 1'b0;
        for (int k = 0; k < 8 && !got; k++) begin
            step();
            if (ack) got = 1'b1;
        end
        chk(got, req, got, 1);
        if (got) begin
            chk(ack_id == IDW'(id), req, ack_id, id);
            chk(vec_addr == PW'(vec), req, vec_addr, vec);
            chk(!gie, req, gie, 0);
            step();
            chk(!ack, {req, " one-cycle ack"}, ack, 0);
        end
    endtask

    task automatic expect_quiet(input string req);
        int seen = 0;
        for (int k = 0; k < 6; k++) begin
            step();
            if (ack) seen++;
        end
        chk(seen == 0, req, seen, 0);
    endtask

    task automatic cleanup();
        irq_req = '0; irq_en = '0; step();
    endtask

    task automatic t_reset_state();
        chk(!ack && !gie, "R11 reset state", {ack, gie}, 0);
    endtask

    task automatic t_gie_ctrl();
        pulse_gie();
        chk(gie, "R11 set", gie, 1);
        gie_clr = 1'b1; step(); gie_clr = 1'b0;
        chk(!gie, "R11 clear", gie, 0);
        gie_set = 1'b1; gie_clr = 1'b1; step(); gie_set = 1'b0; gie_clr = 1'b0;
        chk(gie, "R11 set beats clear", gie, 1);
    endtask

    task automatic t_basic();
        irq_en[3] = 1'b1; irq_req[3] = 1'b1;
        expect_ack("R3 line 3 vector", 4, 8);
        cleanup();
    endtask

    task automatic t_masked_pending();
        pulse_gie();
        irq_req[4] = 1'b1;
        expect_quiet("R1 enable off");
        irq_req[4] = 1'b0; step();
        irq_en[4] = 1'b1;
        expect_ack("R8 held pending", 5, 10);
        cleanup();
        irq_en[1] = 1'b1; irq_req[1] = 1'b1;
        expect_quiet("R1 gie off");
        pulse_gie();
        expect_ack("R1 gie on", 2, 4);
        cleanup();
    endtask

    task automatic t_priority();
        irq_en[2] = 1'b1; irq_en[5] = 1'b1;
        irq_req[2] = 1'b1; irq_req[5] = 1'b1; step(); step();
        pulse_gie();
        expect_ack("R2 lowest first", 3, 6);
        pulse_gie();
        expect_ack("R7 other still pending", 6, 12);
        cleanup();
    endtask

    task automatic t_boundary();
        boundary = 1'b0;
        irq_en[6] = 1'b1; irq_req[6] = 1'b1;
        pulse_gie();
        expect_quiet("R6 no boundary");
        boundary = 1'b1;
        expect_ack("R6 at boundary", 7, 14);
        cleanup();
    endtask

    task automatic t_relocate();
        vec_sel = 1'b1;
        irq_en[0] = 1'b1; irq_req[0] = 1'b1;
        pulse_gie();
        expect_ack("R4 boot table", 1, 32'hC02);
        vec_sel = 1'b0;
        cleanup();
    endtask

    task automatic t_reset_req();
        irq_req[7] = 1'b1; step();
        pulse_gie(); boundary = 1'b0;
        reset_req = 1'b1; step(); reset_req = 1'b0;
        chk(ack && ack_id == 0, "R5 reset ack", {ack, ack_id}, 1 << IDW);
        chk(vec_addr == 0, "R5 reset vector", vec_addr, 0);
        chk(!gie, "R5 gie cleared", gie, 0);
        step();
        boundary = 1'b1; irq_en[7] = 1'b1; pulse_gie();
        expect_quiet("R5 pending cleared");
        vec_sel = 1'b1; reset_req = 1'b1; step(); reset_req = 1'b0;
        chk(ack && vec_addr == BS, "R4 R5 reset in boot table", vec_addr, BS);
        vec_sel = 1'b0;
        cleanup();
    endtask

    task automatic t_lock_a();
        lock_a = 1'b1; pc = 12'hC10;
        irq_en[8] = 1'b1; irq_req[8] = 1'b1;
        pulse_gie();
        expect_quiet("R9 boot region blocked");
        pc = 12'h100;
        expect_ack("R9 app region", 9, 18);
        lock_a = 1'b0;
        cleanup();
    endtask

    task automatic t_lock_b();
        lock_b = 1'b1; vec_sel = 1'b1; pc = 12'h100;
        irq_en[9] = 1'b1; irq_req[9] = 1'b1;
        pulse_gie();
        expect_quiet("R10 app region blocked");
        pc = 12'hC10;
        expect_ack("R10 boot region", 10, 32'hC14);
        lock_b = 1'b0; vec_sel = 1'b0;
        cleanup();
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset_state();
        t_gie_ctrl();
        t_basic();
        t_masked_pending();
        t_priority();
        t_boundary();
        t_relocate();
        t_reset_req();
        t_lock_a();
        t_lock_b();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule